// File: doc/BRIEF.md
# Two-Pointer Clock Page Reclaimer

This engine keeps a small table of physical page frames, each with three flags: resident, used (referenced) and dirty (modified). When the memory manager wants frames back, it raises a request. The engine then sweeps the table with two indices that move in lockstep a fixed number of entries apart. The rear index clears the used flag of each entry it passes. The front index arrives later, and any resident entry whose used flag is still zero is reclaimed. A reclaimed frame's number is pushed into a free-frame FIFO. If the frame was modified, its number is also pushed into a write-back FIFO, so that the page can be copied to backing store.

Memory traffic reports each access through a reference port. A read sets the used flag of the frame, and a store sets both the used flag and the dirty flag. A separate allocate port hands a frame back to the engine once software has placed a new page in it. Choosing how many frames to reclaim, and moving the data to disk, are handled outside the block.

Top module: `clock_reclaim`

## Requirements
- R1: After reset no frame is resident, both FIFOs are empty (`free_valid` and `wb_valid` low), and the rear index is at frame 0.
- R2: A pulse on `alloc_valid` makes frame `alloc_page` resident, sets its used flag to 1 and clears its dirty flag.
- R3: A pulse on `ref_valid` sets the used flag of resident frame `ref_page`. When `ref_write` is also 1, the pulse sets the dirty flag too. A reference to a frame that is not resident has no effect.
- R4: Each scan step moves both indices forward by one frame, wrapping modulo `PAGES`. The front index equals the rear index plus `GAP`, modulo `PAGES`. The rear index clears the used flag of the frame it is on.
- R5: On a scan step, a resident frame under the front index whose used flag is 0 is reclaimed. It becomes non-resident, and its number enters the free FIFO. Frames leave the free FIFO in the order they were reclaimed, head at `free_page` and popped by `free_take`.
- R6: A reclaimed frame whose dirty flag is set also enters the write-back FIFO, in the same order. Frames that are not dirty do not enter it.
- R7: If a reference to the frame under the rear index arrives in the same cycle as that frame's used flag is cleared, the used flag ends at 1.
- R8: A scan step happens only in cycles where `want_free` is 1 and neither FIFO holds `DEPTH` entries. While scanning is stalled, no frame is reclaimed and no frame is lost.
- R9: A reclaimed frame is skipped by every later pass until it is allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| want_free | input | 1 | Request to keep scanning for free frames |
| ref_valid | input | 1 | Reference report strobe |
| ref_page | input | $clog2(PAGES) | Frame touched by the reference |
| ref_write | input | 1 | Reference was a store |
| alloc_valid | input | 1 | Allocate strobe |
| alloc_page | input | $clog2(PAGES) | Frame being made resident |
| free_valid | output | 1 | Free FIFO not empty |
| free_page | output | $clog2(PAGES) | Oldest reclaimed frame |
| free_take | input | 1 | Pop the free FIFO |
| wb_valid | output | 1 | Write-back FIFO not empty |
| wb_page | output | $clog2(PAGES) | Oldest dirty reclaimed frame |
| wb_take | input | 1 | Pop the write-back FIFO |

## Verification
The bench uses 8 frames, a gap of 2 and FIFOs 4 deep, and predicts the scan step on which each frame is freed from the arithmetic of the two indices. Stopping the scan one step before the first reclaim, and then one step after it, exposes a wrong gap or a front index that does not wrap. With the FIFO full, the bench checks that the scan stalls without dropping a frame: a design that kept scanning would lose frames or free them out of order in the next phase. The bench lines up a reference with the clear of the same frame, so a design that lets the clear win frees that frame a full lap early. It also stores to a non-resident frame and then allocates it, so a design that accepts the stray store, or does not clear the dirty flag on allocation, sends a spurious write-back.

// File: rtl/clock_reclaim.sv
module clock_reclaim #(
  parameter int PAGES = 16,
  parameter int GAP   = 4,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     want_free,
  input  logic                     ref_valid,
  input  logic [$clog2(PAGES)-1:0] ref_page,
  input  logic                     ref_write,
  input  logic                     alloc_valid,
  input  logic [$clog2(PAGES)-1:0] alloc_page,
  output logic                     free_valid,
  output logic [$clog2(PAGES)-1:0] free_page,
  input  logic                     free_take,
  output logic                     wb_valid,
  output logic [$clog2(PAGES)-1:0] wb_page,
  input  logic                     wb_take
);
  localparam int AW = $clog2(PAGES);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PAGES-1:0] resident, used, dirty;
  logic [AW-1:0]    trail, lead;
  logic [AW:0]      lead_sum;
  logic [CW-1:0]    fcnt, wcnt;
  logic [QW-1:0]    fwr, frd, wwr, wrd;
  logic [AW-1:0]    fq [DEPTH];
  logic [AW-1:0]    wq [DEPTH];
  logic             step, reclaim, wb_push, ref_ok, fpop, wpop;

  function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
    return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign lead_sum = {1'b0, trail} + (AW+1)'(GAP);
  assign lead     = (int'(lead_sum) >= PAGES) ? AW'(int'(lead_sum) - PAGES) : lead_sum[AW-1:0];

  assign step    = want_free && (fcnt != CW'(DEPTH)) && (wcnt != CW'(DEPTH));
  assign reclaim = step && resident[lead] && !used[lead];
  assign wb_push = reclaim && dirty[lead];
  assign ref_ok  = ref_valid && resident[ref_page] && !(reclaim && ref_page == lead);

  assign fpop       = free_take && free_valid;
  assign wpop       = wb_take && wb_valid;
  assign free_valid = fcnt != '0;
  assign wb_valid   = wcnt != '0;
  assign free_page  = fq[frd];
  assign wb_page    = wq[wrd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resident <= '0;
      used     <= '0;
      dirty    <= '0;
      trail    <= '0;
    end else begin
      if (step) begin
        used[trail] <= 1'b0;
        trail       <= (trail == AW'(PAGES - 1)) ? '0 : trail + 1'b1;
      end
      if (reclaim) begin
        resident[lead] <= 1'b0;
        dirty[lead]    <= 1'b0;
      end
      if (ref_ok) begin
        used[ref_page] <= 1'b1;
        if (ref_write) dirty[ref_page] <= 1'b1;
      end
      if (alloc_valid) begin
        resident[alloc_page] <= 1'b1;
        used[alloc_page]     <= 1'b1;
        dirty[alloc_page]    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt <= '0; fwr <= '0; frd <= '0;
      wcnt <= '0; wwr <= '0; wrd <= '0;
    end else begin
      if (reclaim) fwr <= bump(fwr);
      if (fpop)    frd <= bump(frd);
      fcnt <= fcnt + CW'(reclaim) - CW'(fpop);
      if (wb_push) wwr <= bump(wwr);
      if (wpop)    wrd <= bump(wrd);
      wcnt <= wcnt + CW'(wb_push) - CW'(wpop);
    end
  end

  always_ff @(posedge clk) begin
    if (reclaim) fq[fwr] <= lead;
    if (wb_push) wq[wwr] <= lead;
  end
endmodule

// File: rtl/clock_reclaim_chk.sv
module clock_reclaim_chk #(
  parameter int PAGES = 16,
  parameter int DEPTH = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     step,
  input logic                     reclaim,
  input logic                     wb_push,
  input logic [$clog2(PAGES)-1:0] trail,
  input logic [$clog2(PAGES)-1:0] lead,
  input logic [PAGES-1:0]         resident,
  input logic [PAGES-1:0]         used,
  input logic [$clog2(DEPTH+1)-1:0] fcnt,
  input logic [$clog2(DEPTH+1)-1:0] wcnt,
  input logic                     ref_valid,
  input logic [$clog2(PAGES)-1:0] ref_page,
  input logic                     alloc_valid,
  input logic [$clog2(PAGES)-1:0] alloc_page
);
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(trail));

  a_r4_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> trail != $past(trail));

  a_r5_freed_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    reclaim && !(alloc_valid && alloc_page == lead) |=> !resident[$past(lead)]);

  a_r7_ref_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    step && ref_valid && resident[ref_page] && ref_page == trail && ref_page != lead
    |=> used[$past(ref_page)]);

  a_r8_free_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt == ($clog2(DEPTH+1))'(DEPTH) |-> !reclaim);

  a_r6_wb_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt == ($clog2(DEPTH+1))'(DEPTH) |-> !wb_push);
endmodule

bind clock_reclaim clock_reclaim_chk #(.PAGES(PAGES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .reclaim(reclaim), .wb_push(wb_push),
  .trail(trail), .lead(lead), .resident(resident), .used(used),
  .fcnt(fcnt), .wcnt(wcnt), .ref_valid(ref_valid), .ref_page(ref_page),
  .alloc_valid(alloc_valid), .alloc_page(alloc_page)
);

// File: tb/test_clock_reclaim.sv
module test_clock_reclaim;
  localparam int PAGES = 8;
  localparam int GAP   = 2;
  localparam int DEPTH = 4;
  localparam int AW    = $clog2(PAGES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          want_free = 1'b0;
  logic          ref_valid = 1'b0, ref_write = 1'b0, alloc_valid = 1'b0;
  logic [AW-1:0] ref_page = '0, alloc_page = '0;
  logic          free_valid, wb_valid;
  logic [AW-1:0] free_page, wb_page;
  logic          free_take = 1'b0, wb_take = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clock_reclaim #(.PAGES(PAGES), .GAP(GAP), .DEPTH(DEPTH)) i_clock_reclaim (
    .clk(clk), .rst_n(rst_n), .want_free(want_free),
    .ref_valid(ref_valid), .ref_page(ref_page), .ref_write(ref_write),
    .alloc_valid(alloc_valid), .alloc_page(alloc_page),
    .free_valid(free_valid), .free_page(free_page), .free_take(free_take),
    .wb_valid(wb_valid), .wb_page(wb_page), .wb_take(wb_take)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic alloc(input int p);
    alloc_valid = 1'b1; alloc_page = AW'(p);
    @(negedge clk); alloc_valid = 1'b0;
  endtask

  task automatic touch(input int p, input bit wr);
    ref_valid = 1'b1; ref_page = AW'(p); ref_write = wr;
    @(negedge clk); ref_valid = 1'b0; ref_write = 1'b0;
  endtask

  task automatic scan(input int n);
    want_free = 1'b1;
    repeat (n) @(negedge clk);
    want_free = 1'b0;
  endtask

  task automatic pop_free(input string tag, input int exp);
    chk({tag, " free_valid"}, int'(free_valid), 1);
    chk({tag, " free_page"}, int'(free_page), exp);
    free_take = 1'b1; @(negedge clk); free_take = 1'b0;
  endtask

  task automatic pop_wb(input string tag, input int exp);
    chk({tag, " wb_valid"}, int'(wb_valid), 1);
    chk({tag, " wb_page"}, int'(wb_page), exp);
    wb_take = 1'b1; @(negedge clk); wb_take = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 free empty", int'(free_valid), 0);
    chk("R1 wb empty", int'(wb_valid), 0);
    scan(12);
    chk("R1 nothing resident to free", int'(free_valid), 0);
    // rear index is back at 12 mod 8 = 4; reset again for a clean origin
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;

    for (int p = 0; p < PAGES; p++) alloc(p);
    touch(1, 1'b1);
    touch(3, 1'b1);
    // frame p is cleared on step p and first reclaimed on step p+PAGES-GAP
    scan(PAGES - GAP);
    chk("R4 no free before gap lap", int'(free_valid), 0);
    scan(1);
    chk("R4 first free after gap lap", int'(free_valid), 1);
    chk("R5 first freed frame", int'(free_page), 0);
    scan(30);
    pop_free("R5", 0);
    pop_free("R5", 1);
    pop_free("R5", 2);
    pop_free("R5", 3);
    chk("R8 stalled when full", int'(free_valid), 0);
    pop_wb("R6", 1);
    pop_wb("R6", 3);
    chk("R6 only dirty written back", int'(wb_valid), 0);

    repeat (20) @(negedge clk);
    chk("R8 no scan without request", int'(free_valid), 0);
    touch(5, 1'b0);
    touch(6, 1'b1);
    scan(40);
    pop_free("R3 R9", 4);
    pop_free("R3 R9", 7);
    pop_free("R3 R9", 5);
    pop_free("R3 R9", 6);
    chk("R9 freed frames not freed again", int'(free_valid), 0);
    pop_wb("R3 store marks dirty", 6);
    chk("R3 read leaves clean", int'(wb_valid), 0);

    // rear index now at 5, front at 7
    touch(7, 1'b1);
    alloc(5);
    alloc(7);
    want_free = 1'b1; ref_valid = 1'b1; ref_page = 3'd5; ref_write = 1'b0;
    @(negedge clk); ref_valid = 1'b0;
    repeat (6) @(negedge clk);
    want_free = 1'b0;
    chk("R7 reference beats clear", int'(free_valid), 0);
    scan(20);
    pop_free("R7", 7);
    pop_free("R7", 5);
    chk("R7 no extra frees", int'(free_valid), 0);
    chk("R2 R3 allocated frame clean", int'(wb_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule